// File: doc/BRIEF.md
# K-Slow Interleaved First-Order Recursive Filter

This block computes the first-order recursion y = a·y_prev + x for several independent sample streams on one shared multiplier and adder. Each register in the feedback loop is expanded into K registers, so the loop carries K separate channel states at once. Channel c owns slot c of a free-running modulo-K slot counter. With K streams presented one per slot, the arithmetic unit does useful work on every clock.

Samples arrive on one time-multiplexed bus that carries a channel tag and a valid flag. Each channel has its own signed fixed-point coefficient. Results leave on an interleaved output stream whose tag names the channel that produced them. In single-stream mode only slot 0 accepts data. The other K-1 slots become null operations, which pass each channel's state around the loop unchanged, so the unit is busy one cycle in K.

A build parameter selects where the loop registers sit. In the direct form the multiply and the add are both in one cycle. In the retimed form one of the K loop registers moves between the multiplier and the adder, which shortens the critical path. The loop still holds K registers in total, and the behaviour at the ports is the same for both forms.

Top module: `kslow_recursor`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears every channel state and the output register. In the first cycle after reset, outValid is 0, and the first accepted sample of each channel produces clip(x), as if the previous state were zero.
- R2: The slot counter is 0 in the first cycle after reset and advances by one every clock, wrapping from K-1 to 0. In interleaved mode (singleMode=0), inReady is 1 exactly when inTag equals the current slot. A tag of K or more is never ready.
- R3: An accepted sample x on channel c updates that channel's state to clip(floor(a_c·y_prev / 2^FRAC) + x). The coefficient a_c is the signed field coefBus[c*CW +: CW], and with the defaults it is Q2.14 (FRAC=14). Channels never affect each other. A coefficient must be stable from the cycle before an acceptance through that acceptance.
- R4: A sample accepted in a cycle (inValid and inReady both 1) gives outValid=1 in the next cycle, with outTag equal to the accepted slot and outData equal to the new state.
- R5: A slot without an acceptance is a null operation. It leaves that channel's state unchanged and gives outValid=0 in the next cycle.
- R6: In single-stream mode (singleMode=1), inReady is 1 only when the slot is 0, whatever inTag is. An accepted sample updates channel 0 with coefficient a_0, and its result carries outTag 0.
- R7: Results outside the signed DW-bit range are clipped to 2^(DW-1)-1 or -2^(DW-1).
- R8: The direct form (RETIME=0) and the retimed form (RETIME=1) produce identical inReady, outValid, outTag and outData for identical input sequences.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| singleMode | input | 1 | 1: one stream in slot 0; 0: K interleaved streams |
| inValid | input | 1 | Input sample present |
| inTag | input | $clog2(K) | Channel tag of the input sample |
| inData | input | DW | Signed input sample |
| coefBus | input | K*CW | Per-channel signed coefficients, channel c at bits c*CW +: CW |
| inReady | output | 1 | Current slot accepts the offered sample |
| outValid | output | 1 | Result present |
| outTag | output | $clog2(K) | Channel of the result |
| outData | output | DW | Signed, clipped result |

## Verification
The hardest case to reach is a channel that has non-zero state and then sits through a run of null slots, or a change of mode, before its next acceptance. The state must come back intact after passing around the loop, which in the retimed form goes through the bypass copy beside the product register. The stimulus mixes random valid gaps, tags that do not match the slot, tags beyond the channel count and random toggling of single-stream mode. A mid-run reset and a phase with coefficients near ±2 drive the clip limits and the zero-state restart. Both placement variants run side by side against one behavioural model.

// File: rtl/kslow_pkg.sv
package kslow_pkg;

  // Per-cycle strobes from the slot control to the datapath.
  typedef struct packed {
    logic accept;  // a sample is taken in this slot
    logic nullOp;  // slot carries no sample: channel state passes unchanged
  } slotStrobe_t;

endpackage

// File: rtl/kslow_ctrl.sv
module kslow_ctrl #(
  parameter int K = 2,
  parameter bit RETIME = 1'b1,
  localparam int TW = $clog2(K)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   singleMode,
  input  logic                   inValid,
  input  logic [TW-1:0]          inTag,
  output logic                   inReady,
  output kslow_pkg::slotStrobe_t ctl,
  output logic [TW-1:0]          coefIdx,
  output logic [TW-1:0]          tagNow
);

  logic [TW-1:0] slotQ;
  logic [TW-1:0] slotNxt;
  logic          takeIt;

  assign slotNxt = (slotQ == TW'(K - 1)) ? '0 : slotQ + TW'(1);

  always_ff @(posedge clk) begin
    if (rst) slotQ <= '0;
    else     slotQ <= slotNxt;
  end

  // Slot ownership: one stream in slot 0, or the tag has to match the slot.
  assign inReady = singleMode ? (slotQ == '0) : (inTag == slotQ);
  assign takeIt  = inValid & inReady;

  assign ctl.accept = takeIt;
  assign ctl.nullOp = ~takeIt;

  // In the retimed form the product is formed one slot early.
  assign coefIdx = RETIME ? slotNxt : slotQ;
  assign tagNow  = slotQ;

endmodule

// File: rtl/kslow_dpath.sv
module kslow_dpath #(
  parameter int K = 2,
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int FRAC = 14,
  parameter bit RETIME = 1'b1,
  localparam int TW = $clog2(K)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  kslow_pkg::slotStrobe_t ctl,
  input  logic [TW-1:0]          coefIdx,
  input  logic [TW-1:0]          tagNow,
  input  logic signed [DW-1:0]   sampleIn,
  input  logic [K*CW-1:0]        coefBus,
  output logic                   resValid,
  output logic [TW-1:0]          resTag,
  output logic signed [DW-1:0]   resData
);

  localparam int PW = DW + CW;
  // Loop registers in the state ring; the retimed form moves one into the product path.
  localparam int RL = RETIME ? K - 1 : K;
  localparam logic signed [PW:0] MAXV = {{(PW-DW+2){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [PW:0] MINV = {{(PW-DW+2){1'b1}}, {(DW-1){1'b0}}};

  logic signed [DW-1:0] ringQ [RL];
  logic signed [DW-1:0] tap;
  logic signed [CW-1:0] coefSel;
  logic signed [PW-1:0] prodFull;
  logic signed [PW-1:0] prodScaled;
  logic signed [PW-1:0] addend;
  logic signed [DW-1:0] passVal;
  logic signed [PW:0]   sumW;
  logic signed [DW-1:0] clipped;
  logic signed [DW-1:0] newVal;

  assign tap      = ringQ[RL-1];
  assign coefSel  = coefBus[int'(coefIdx)*CW +: CW];
  assign prodFull = PW'(tap) * PW'(coefSel);
  assign prodScaled = prodFull >>> FRAC;

  generate
    if (RETIME) begin : gRetimed
      logic signed [PW-1:0] prodQ;
      logic signed [DW-1:0] holdQ;
      always_ff @(posedge clk) begin
        if (rst) begin
          prodQ <= '0;
          holdQ <= '0;
        end else begin
          prodQ <= prodScaled;
          holdQ <= tap;
        end
      end
      assign addend  = prodQ;
      assign passVal = holdQ;
    end else begin : gDirect
      assign addend  = prodScaled;
      assign passVal = tap;
    end
  endgenerate

  assign sumW = (PW+1)'(addend) + (PW+1)'(sampleIn);

  always_comb begin
    if (sumW > MAXV)      clipped = MAXV[DW-1:0];
    else if (sumW < MINV) clipped = MINV[DW-1:0];
    else                  clipped = sumW[DW-1:0];
  end

  assign newVal = ctl.nullOp ? passVal : clipped;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < RL; i++) ringQ[i] <= '0;
      resValid <= 1'b0;
      resTag   <= '0;
      resData  <= '0;
    end else begin
      ringQ[0] <= newVal;
      for (int i = 1; i < RL; i++) ringQ[i] <= ringQ[i-1];
      resValid <= ctl.accept;
      resTag   <= tagNow;
      resData  <= newVal;
    end
  end

endmodule

// File: rtl/kslow_recursor.sv
module kslow_recursor #(
  parameter int K = 2,
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int FRAC = 14,
  parameter bit RETIME = 1'b1,
  localparam int TW = $clog2(K)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 singleMode,
  input  logic                 inValid,
  input  logic [TW-1:0]        inTag,
  input  logic signed [DW-1:0] inData,
  input  logic [K*CW-1:0]      coefBus,
  output logic                 inReady,
  output logic                 outValid,
  output logic [TW-1:0]        outTag,
  output logic signed [DW-1:0] outData
);

  kslow_pkg::slotStrobe_t ctl;
  logic [TW-1:0] coefIdx;
  logic [TW-1:0] tagNow;

  kslow_ctrl #(.K(K), .RETIME(RETIME)) uCtrl (
    .clk(clk), .rst(rst), .singleMode(singleMode), .inValid(inValid),
    .inTag(inTag), .inReady(inReady), .ctl(ctl), .coefIdx(coefIdx),
    .tagNow(tagNow)
  );

  kslow_dpath #(.K(K), .DW(DW), .CW(CW), .FRAC(FRAC), .RETIME(RETIME)) uDpath (
    .clk(clk), .rst(rst), .ctl(ctl), .coefIdx(coefIdx), .tagNow(tagNow),
    .sampleIn(inData), .coefBus(coefBus), .resValid(outValid),
    .resTag(outTag), .resData(outData)
  );

endmodule

// File: rtl/kslow_recursor_chk.sv
module kslow_recursor_chk #(
  parameter int K = 2,
  localparam int TW = $clog2(K)
) (
  input logic          clk,
  input logic          rst,
  input logic          singleMode,
  input logic          inValid,
  input logic [TW-1:0] inTag,
  input logic          inReady,
  input logic          outValid,
  input logic [TW-1:0] outTag
);

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !outValid);  // R1

  AST_TAG_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (inReady && !singleMode) |-> (int'(inTag) < K));  // R2

  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady) |=> outValid);  // R4

  AST_TAG_CARRIED: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady && !singleMode) |=> (outTag == $past(inTag)));  // R4

  AST_NULL_SILENT: assert property (@(posedge clk) disable iff (rst)
    !(inValid && inReady) |=> !outValid);  // R5

  AST_SINGLE_SPACED: assert property (@(posedge clk) disable iff (rst)
    (singleMode && inReady) |=> (!singleMode || !inReady));  // R6

  AST_SINGLE_TAG_ZERO: assert property (@(posedge clk) disable iff (rst)
    (singleMode && inValid && inReady) |=> (outTag == '0));  // R6

endmodule

bind kslow_recursor kslow_recursor_chk #(.K(K)) uChk (
  .clk(clk), .rst(rst), .singleMode(singleMode), .inValid(inValid),
  .inTag(inTag), .inReady(inReady), .outValid(outValid), .outTag(outTag)
);

// File: tb/sim_kslow_recursor.sv
`timescale 1ns/1ps
module sim_kslow_recursor;

  localparam int K = 3;
  localparam int DW = 16;
  localparam int CW = 16;
  localparam int FRAC = 14;
  localparam int TW = $clog2(K);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic singleMode = 1'b0;
  logic inValid = 1'b0;
  logic [TW-1:0] inTag = '0;
  logic signed [DW-1:0] inData = '0;
  logic [K*CW-1:0] coefBus = '0;

  logic rdy0, ov0, rdy1, ov1;
  logic [TW-1:0] ot0, ot1;
  logic signed [DW-1:0] od0, od1;

  always #4 clk = ~clk;  // 125 MHz

  kslow_recursor #(.K(K), .DW(DW), .CW(CW), .FRAC(FRAC), .RETIME(1'b1)) u0 (
    .clk(clk), .rst(rst), .singleMode(singleMode), .inValid(inValid),
    .inTag(inTag), .inData(inData), .coefBus(coefBus), .inReady(rdy0),
    .outValid(ov0), .outTag(ot0), .outData(od0));

  kslow_recursor #(.K(K), .DW(DW), .CW(CW), .FRAC(FRAC), .RETIME(1'b0)) u1 (
    .clk(clk), .rst(rst), .singleMode(singleMode), .inValid(inValid),
    .inTag(inTag), .inData(inData), .coefBus(coefBus), .inReady(rdy1),
    .outValid(ov1), .outTag(ot1), .outData(od1));

  int nChecks = 0;
  int nFail = 0;
  int coef [K];
  int st [K];
  int mslot = 0;
  bit expV = 1'b0;
  int expT = 0;
  int expD = 0;
  string dataReq = "R3";

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int clipv(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  task automatic loadCoefs();
    for (int c = 0; c < K; c++) coefBus[c*CW +: CW] = coef[c][CW-1:0];
  endtask

  // Called at a falling edge: check last edge's result, drive, check ready, advance model.
  task automatic step(input bit v, input int tag, input int data);
    bit expR;
    longint p;
    int y;
    chk(ov0 === expV, expV ? "R4 outValid" : "R5 outValid", ov0, expV);
    chk(ov1 === ov0, "R8 outValid", ov1, ov0);
    if (expV) begin
      chk(int'(ot0) == expT, "R4 outTag", ot0, expT);
      chk(int'(od0) == expD, dataReq, od0, expD);
      chk(ot1 == ot0 && od1 == od0, "R8 result", od1, od0);
    end
    inValid = v;
    inTag   = tag[TW-1:0];
    inData  = data[DW-1:0];
    #1;
    expR = singleMode ? (mslot == 0) : (tag == mslot);
    chk(rdy0 === expR, singleMode ? "R6 inReady" : "R2 inReady", rdy0, expR);
    chk(rdy1 === rdy0, "R8 inReady", rdy1, rdy0);
    if (v && expR) begin
      p = longint'(coef[mslot]) * longint'(st[mslot]);
      y = clipv((p >>> FRAC) + longint'(data));
      st[mslot] = y;
      expV = 1'b1;
      expT = mslot;
      expD = y;
    end else begin
      expV = 1'b0;
    end
    mslot = (mslot + 1) % K;
    @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    inValid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int c = 0; c < K; c++) st[c] = 0;
    mslot = 0;
    expV = 1'b0;
    chk(ov0 === 1'b0, "R1 outValid after reset", ov0, 0);
  endtask

  // Interleaved, one sample per slot with the matching tag.
  task automatic fullRun(input int n, input int span);
    for (int i = 0; i < n; i++)
      step(1'b1, mslot, $signed($urandom % (2*span)) - span);
  endtask

  initial begin
    for (int c = 0; c < K; c++) coef[c] = 8192 + c * 3000;
    loadCoefs();
    doReset();

    // R1: first sample per channel starts from zero state
    dataReq = "R1 first result";
    fullRun(K, 5000);
    dataReq = "R3 recursion";
    fullRun(120, 6000);

    // R5 / R2: gaps, wrong tags, out-of-range tags
    for (int i = 0; i < 300; i++)
      step(($urandom % 2) == 0, $urandom % 4, $signed($urandom % 12000) - 6000);

    // coefficient change: only before an idle slot
    step(1'b0, 0, 0);
    for (int c = 0; c < K; c++) coef[c] = $signed($urandom % 32768) - 16384;
    loadCoefs();
    step(1'b0, 0, 0);
    fullRun(60, 8000);

    // R6: single-stream mode, tag ignored
    dataReq = "R6 single stream";
    singleMode = 1'b1;
    for (int i = 0; i < 90; i++) step(1'b1, $urandom % 4, $signed($urandom % 8000) - 4000);
    // mixed mode toggling
    dataReq = "R5 state held across null slots";
    for (int i = 0; i < 200; i++) begin
      singleMode = ($urandom % 3) == 0;
      step(($urandom % 3) != 0, $urandom % 4, $signed($urandom % 8000) - 4000);
    end
    singleMode = 1'b0;

    // R7: clip high, then alternate both limits
    step(1'b0, 0, 0);
    coef[0] = 32767; coef[1] = -32768; coef[2] = 32767;
    loadCoefs();
    step(1'b0, 0, 0);
    dataReq = "R7 clipping";
    for (int i = 0; i < 8; i++) begin
      step(1'b1, 0, 20000);
      step(1'b1, 1, -20000);
      step(1'b1, 2, -32768);
    end

    // R1: mid-run reset restarts every channel from zero
    doReset();
    dataReq = "R1 restart";
    fullRun(K, 9000);
    dataReq = "R3 recursion";
    fullRun(30, 9000);
    step(1'b0, 0, 0);
    step(1'b0, 0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule